// File: doc/BRIEF.md
# Phase-Accumulator NCO with Banked Tuning and Phase Offset

This block is the digital core of a direct digital synthesizer. Each clock it adds a 32-bit tuning word to a phase accumulator, so the output frequency is the tuning word times the clock rate divided by 2^32. The upper 14 bits of the phase, plus a selectable 5-bit phase offset, address a quarter-wave sine table. The two top phase bits fold that table into a full period. The result is a signed 10-bit amplitude word for a DAC.

There are two tuning-word registers and four phase-offset registers. They are written through plain parallel inputs with a write strobe and an index. Select pins pick the active tuning word (frequency shift keying) and the active offset (phase shift keying).

An optional dither of roughly half an output LSB can be added ahead of the final truncation. It comes from a 16-bit LFSR and breaks up quantization spurs. The amplitude leaves as a free-running sample stream, one word per clock. It has no valid or ready handshake: a DAC cannot apply back-pressure, so none is accepted and none is signalled.

Top module: `dds_nco`

## Requirements
- R1: The 32-bit accumulator adds the tuning word selected by `fsel` on every rising edge, wrapping modulo 2^32.
- R2: The table phase is the accumulator's upper 14 bits plus the selected 5-bit offset shifted left by 9, taken modulo 2^14. Offset bit 4 weighs 180° and bit 0 weighs 11.25°.
- R3: Table entry k (0..4095) is round(4095·sin(π/2·(k+0.5)/4096)). The phase is split into quadrant q = phase[13:12] and address a = phase[11:0]. The signed sine word is +T[a] for q=0, +T[4095−a] for q=1, −T[a] for q=2 and −T[4095−a] for q=3.
- R4: `amp_o` is floor(sine word / 8) as a 10-bit two's-complement value. The accumulator value held during clock cycle n reaches `amp_o` in cycle n+3.
- R5: A pulse of `freq_we` stores `freq_wdata` into tuning register `freq_waddr`. The new word is first added on the following rising edge. `fsel` is sampled on the edge that performs the addition.
- R6: A pulse of `phase_we` stores `phase_wdata` into offset register `phase_waddr`. `psel` is sampled on the same edge that captures the accumulator value.
- R7: Writing or switching the tuning word never alters the accumulator's current value. Only the increment applied from then on changes, so the phase stays continuous.
- R8: While `dither_en` is high, the LFSR's low 3 bits, read as a signed value from −4 to 3, are added to the sine word before truncation. The sum saturates at −4096 and +4095 instead of wrapping.
- R9: The dither LFSR is 16 bits, reset to 0x0001, and shifts left every clock. Its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. The value used at an edge is the state held before that edge's shift.
- R10: A synchronous reset clears the accumulator, all tuning and offset registers, and every pipeline stage, so `amp_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_we | input | 1 | Tuning-word write strobe |
| freq_waddr | input | 1 | Index of the tuning register to write |
| freq_wdata | input | 32 | Tuning word to store |
| phase_we | input | 1 | Phase-offset write strobe |
| phase_waddr | input | 2 | Index of the offset register to write |
| phase_wdata | input | 5 | Phase offset to store |
| fsel | input | 1 | Selects the active tuning register |
| psel | input | 2 | Selects the active offset register |
| dither_en | input | 1 | Enables LFSR dither ahead of truncation |
| amp_o | output | 10 | Signed amplitude sample for the DAC |

## Verification
A register write changes the accumulation one edge later. A select change acts on the edge at which it is sampled. The accumulator value, the offset selection and the dither choice made at an edge reach `amp_o` three, two and one edges later respectively. The bench keeps a cycle model that advances on each rising edge under exactly these rules. Inputs change only at falling edges, and `amp_o` is compared at every falling edge, so each comparison lands on the cycle in which the result is due.

// File: rtl/dds_nco_pkg.sv
package dds_nco_pkg;

  typedef logic [15:0] lfsr_t;

  // maximal-length sequence, polynomial x^16 + x^14 + x^13 + x^11 + 1
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/dds_nco_acc.sv
module dds_nco_acc #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 14,
  parameter int N_FREQ = 2,
  localparam int FW    = $clog2(N_FREQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [FW-1:0]    waddr,
  input  logic [ACC_W-1:0] wdata,
  input  logic [FW-1:0]    fsel,
  output logic [PH_W-1:0]  acc_top
);

  logic [ACC_W-1:0] bank [N_FREQ];
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc;

  assign step    = bank[fsel];
  assign acc_top = acc[ACC_W-1 -: PH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_FREQ; i++) bank[i] <= '0;
      acc <= '0;
    end else begin
      if (we) bank[waddr] <= wdata;
      acc <= acc + step;
    end
  end

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> $stable(acc));

endmodule

// File: rtl/dds_nco_phase.sv
module dds_nco_phase #(
  parameter int PH_W    = 14,
  parameter int OFS_W   = 5,
  parameter int N_PHASE = 4,
  localparam int PW     = $clog2(N_PHASE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [OFS_W-1:0] wdata,
  input  logic [PW-1:0]    psel,
  input  logic [PH_W-1:0]  acc_top,
  output logic [PH_W-1:0]  ph_q
);

  logic [OFS_W-1:0] bank [N_PHASE];
  logic [PH_W-1:0]  ofs_al;

  // offset aligned to the most significant phase bits
  assign ofs_al = {bank[psel], {(PH_W-OFS_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PHASE; i++) bank[i] <= '0;
      ph_q <= '0;
    end else begin
      if (we) bank[waddr] <= wdata;
      ph_q <= acc_top + ofs_al;
    end
  end

endmodule

// File: rtl/dds_nco_lut.sv
module dds_nco_lut #(
  parameter int PH_W  = 14,
  parameter int MAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  ph,
  output logic [MAG_W-1:0] mag_q,
  output logic             neg_q
);

  localparam int  QW      = PH_W - 2;
  localparam int  QN      = 1 << QW;
  localparam real HALF_PI = 1.5707963267948966;
  localparam real FULL    = real'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] rom [QN];
  logic [QW-1:0]    idx;

  // quarter wave sampled at half-step centres, so mirroring is exact
  initial begin
    for (int k = 0; k < QN; k++)
      rom[k] = MAG_W'($rtoi(FULL * $sin(HALF_PI * (real'(k) + 0.5) / real'(QN)) + 0.5));
  end

  // odd quadrants walk the quarter wave backwards
  assign idx = ph[PH_W-2] ? ~ph[QW-1:0] : ph[QW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else begin
      mag_q <= rom[idx];
      neg_q <= ph[PH_W-1];
    end
  end

endmodule

// File: rtl/dds_nco_out.sv
module dds_nco_out
  import dds_nco_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MAG_W-1:0]        mag,
  input  logic                    neg,
  input  logic                    dither_en,
  output logic signed [OUT_W-1:0] amp_o
);

  localparam int SW   = MAG_W + 1;
  localparam int DROP = SW - OUT_W;

  lfsr_t                  lfsr;
  logic signed [SW-1:0]   sw;
  logic signed [SW:0]     dith;
  logic signed [SW:0]     sum;
  logic [SW-1:0]          clipped;
  logic signed [OUT_W-1:0] sw_tr;

  assign sw   = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  assign dith = dither_en ? {{(SW+1-DROP){lfsr[DROP-1]}}, lfsr[DROP-1:0]} : '0;
  assign sum  = {sw[SW-1], sw} + dith;

  // clamp on overflow of the extended sum
  always_comb begin
    if (sum[SW] != sum[SW-1])
      clipped = sum[SW] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    else
      clipped = sum[SW-1:0];
  end

  assign sw_tr = sw[SW-1:DROP];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= 16'h0001;
      amp_o <= '0;
    end else begin
      lfsr  <= lfsr_step(lfsr);
      amp_o <= clipped[SW-1:DROP];
    end
  end

  logic signed [OUT_W:0] amp_x, base_x;
  localparam logic signed [OUT_W:0] ONE = 1;
  assign amp_x  = {amp_o[OUT_W-1], amp_o};
  assign base_x = {sw_tr[OUT_W-1], sw_tr};

  // R3
  sign_fold_chk: assert property (@(posedge clk) disable iff (rst)
    !dither_en |=> (amp_o[OUT_W-1] == $past(neg)));

  // R8
  dither_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dither_en |=> ((amp_x - $past(base_x)) <= ONE) && ((amp_x - $past(base_x)) >= -ONE));

  // R9
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

endmodule

// File: rtl/dds_nco.sv
module dds_nco
  import dds_nco_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 14,
  parameter int OFS_W   = 5,
  parameter int MAG_W   = 12,
  parameter int OUT_W   = 10,
  parameter int N_FREQ  = 2,
  parameter int N_PHASE = 4,
  localparam int FW     = $clog2(N_FREQ),
  localparam int PW     = $clog2(N_PHASE)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    freq_we,
  input  logic [FW-1:0]           freq_waddr,
  input  logic [ACC_W-1:0]        freq_wdata,
  input  logic                    phase_we,
  input  logic [PW-1:0]           phase_waddr,
  input  logic [OFS_W-1:0]        phase_wdata,
  input  logic [FW-1:0]           fsel,
  input  logic [PW-1:0]           psel,
  input  logic                    dither_en,
  output logic signed [OUT_W-1:0] amp_o
);

  logic [PH_W-1:0]  acc_top;
  logic [PH_W-1:0]  ph;
  logic [MAG_W-1:0] mag;
  logic             neg;

  dds_nco_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .N_FREQ(N_FREQ)) u_acc (
    .clk(clk), .rst(rst), .we(freq_we), .waddr(freq_waddr),
    .wdata(freq_wdata), .fsel(fsel), .acc_top(acc_top)
  );

  dds_nco_phase #(.PH_W(PH_W), .OFS_W(OFS_W), .N_PHASE(N_PHASE)) u_phase (
    .clk(clk), .rst(rst), .we(phase_we), .waddr(phase_waddr),
    .wdata(phase_wdata), .psel(psel), .acc_top(acc_top), .ph_q(ph)
  );

  dds_nco_lut #(.PH_W(PH_W), .MAG_W(MAG_W)) u_lut (
    .clk(clk), .rst(rst), .ph(ph), .mag_q(mag), .neg_q(neg)
  );

  dds_nco_out #(.MAG_W(MAG_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .mag(mag), .neg(neg),
    .dither_en(dither_en), .amp_o(amp_o)
  );

endmodule

// File: tb/dds_nco_bench.sv
module dds_nco_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        freq_we = 1'b0;
  logic        freq_waddr = 1'b0;
  logic [31:0] freq_wdata = '0;
  logic        phase_we = 1'b0;
  logic [1:0]  phase_waddr = '0;
  logic [4:0]  phase_wdata = '0;
  logic        fsel = 1'b0;
  logic [1:0]  psel = '0;
  logic        dither_en = 1'b0;
  logic signed [9:0] amp_o;

  dds_nco u_dds_nco (
    .clk(clk), .rst(rst), .freq_we(freq_we), .freq_waddr(freq_waddr),
    .freq_wdata(freq_wdata), .phase_we(phase_we), .phase_waddr(phase_waddr),
    .phase_wdata(phase_wdata), .fsel(fsel), .psel(psel),
    .dither_en(dither_en), .amp_o(amp_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // cycle model built from the requirements
  logic [31:0] acc_m;
  logic [31:0] fr_m [2];
  logic [4:0]  po_m [4];
  logic [15:0] lf_m;
  int ph1_m, sine2_m, out_m;

  // R3: folded quarter-wave table value for a 14-bit phase
  function automatic int sine_of(int p);
    int q, a, m;
    q = (p >> 12) & 3;
    a = p & 4095;
    if (q[0]) a = 4095 - a;
    m = $rtoi(4095.0 * $sin(1.5707963267948966 * (real'(a) + 0.5) / 4096.0) + 0.5);
    return q[1] ? -m : m;
  endfunction

  always @(posedge clk) begin
    int s, nout, nsine, nph;
    if (rst) begin
      acc_m = '0; fr_m[0] = '0; fr_m[1] = '0;
      for (int i = 0; i < 4; i++) po_m[i] = '0;
      lf_m = 16'h0001; ph1_m = 0; sine2_m = 0; out_m = 0;
    end else begin
      s = sine2_m;
      if (dither_en) s = s + int'($signed(lf_m[2:0]));   // R8
      if (s > 4095) s = 4095;
      if (s < -4096) s = -4096;
      nout  = s >>> 3;                                     // R4
      nsine = sine_of(ph1_m);
      nph   = int'(((acc_m >> 18) + (32'(po_m[psel]) << 9)) & 32'h3FFF); // R2
      acc_m = acc_m + fr_m[fsel];                          // R1
      lf_m  = {lf_m[14:0], lf_m[15] ^ lf_m[13] ^ lf_m[12] ^ lf_m[10]}; // R9
      if (freq_we)  fr_m[freq_waddr]  = freq_wdata;        // R5
      if (phase_we) po_m[phase_waddr] = phase_wdata;       // R6
      out_m = nout; sine2_m = nsine; ph1_m = nph;
    end
  end

  task automatic chk(string tag, int exp);
    int act;
    act = int'(amp_o);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: amp_o=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    chk(tag, out_m);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr_freq(logic a, logic [31:0] d, string tag);
    freq_we = 1'b1; freq_waddr = a; freq_wdata = d;
    tick(tag);
    freq_we = 1'b0;
  endtask

  task automatic wr_phase(logic [1:0] a, logic [4:0] d, string tag);
    phase_we = 1'b1; phase_waddr = a; phase_wdata = d;
    tick(tag);
    phase_we = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 reset output", 0);
    end
    rst = 1'b0;
  endtask

  task automatic t_tone();
    wr_freq(1'b0, 32'h4000_0000, "R1 quarter-turn step");
    ticks(12, "R4 latency and truncation");
  endtask

  task automatic t_sweep();
    wr_freq(1'b0, 32'h0123_4567, "R1 odd step");
    ticks(300, "R3 all quadrants");
  endtask

  task automatic t_fsk();
    wr_freq(1'b1, 32'h0800_0000, "R5 write bank 1");
    for (int i = 0; i < 10; i++) begin
      fsel = ~fsel;
      ticks(3, "R5 frequency select");
    end
    fsel = 1'b0;
  endtask

  task automatic t_retune();
    wr_freq(1'b0, 32'h0200_0000, "R7 retune a");
    ticks(7, "R7 continuity");
    wr_freq(1'b0, 32'hF000_0001, "R7 retune b");
    ticks(7, "R7 continuity");
    wr_freq(1'b0, 32'h0000_0000, "R7 freeze");
    ticks(10, "R7 hold");
    wr_freq(1'b0, 32'h0345_6789, "R7 resume");
    ticks(10, "R7 continuity");
  endtask

  task automatic t_psk();
    wr_phase(2'd1, 5'd16, "R6 write 180");
    wr_phase(2'd2, 5'd8,  "R6 write 90");
    wr_phase(2'd3, 5'd1,  "R6 write 11.25");
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 4; k++) begin
        psel = 2'(k);
        ticks(4, "R2 phase offset select");
      end
    psel = 2'd0;
  endtask

  task automatic t_dither();
    dither_en = 1'b1;
    ticks(400, "R9 dither sequence");
    dither_en = 1'b0;
    ticks(5, "R8 dither off");
  endtask

  task automatic t_sat();
    t_reset();
    dither_en = 1'b1;
    wr_phase(2'd0, 5'd8, "R8 positive peak");
    ticks(80, "R8 positive saturation");
    wr_phase(2'd0, 5'd24, "R8 negative peak");
    ticks(80, "R8 negative saturation");
    dither_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_tone();
    t_sweep();
    t_fsk();
    t_retune();
    t_psk();
    t_dither();
    t_sat();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule